// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Refill Controller

This block is the instruction-side cache of a fetch unit. A fetch address arrives over a valid/ready request channel. When the addressed word is held in the cache, the request is accepted in the same cycle and the instruction comes back one cycle later.

When the word is not in the cache, the block starts loading the whole line from a backing store. That store is modelled inside the block. It returns the missing word first and then the rest of the line in wrap-around order. Words arrive two at a time with one idle cycle between pairs. Once a line load has begun it always finishes. While it runs, the cache keeps answering requests that hit, including words of the line being loaded that have already landed.

Back-pressure rules on the request side:
- While `fetch_ready` is low, the requester keeps `fetch_valid` high and holds `fetch_addr` unchanged.
- A request counts as taken on a clock edge where both `fetch_valid` and `fetch_ready` are high.
- The response side has no back-pressure. `instr_valid` is a one-cycle pulse that the consumer must accept.

A miss that arrives while a line load is running waits until that load has finished. Only then does its own load begin.

Top module: `ifetch_cache`

## Requirements
- R1: Addresses are byte addresses. Bits [1:0] are ignored, bits [4:2] pick the word within an 8-word line, bits [11:5] pick one of 128 lines, and bits [31:12] form the tag. Two addresses with the same line number but different tags evict one another.
- R2: On a hit, `fetch_ready` is high in the cycle the request is presented, and `instr_valid` is high the next cycle. The word returned for byte address A is always (A >> 2) XOR 32'hC3A5_5A3C.
- R3: A request that misses while no load is running sets cycle 0. `fetch_ready` stays low until the missing word is delivered, and its `instr_valid` appears in cycle 7.
- R4: A load delivers the word at offset (critical + j) mod 8 as its j-th word. That word is available in cycle 7 + 3*(j/2) + (j mod 2), so the load is complete by cycle 17.
- R5: A load is never abandoned when the requester moves elsewhere. After it completes, every word of the line hits with one-cycle latency.
- R6: While a load runs, requests that hit other lines are still served with one-cycle latency.
- R7: A request for a word of the line being loaded is served as a hit once that word has arrived. Before that, it is held and accepted on the cycle that word arrives.
- R8: A miss to a different line made during a load is held until the load ends. Its own load then starts in cycle 17, and its word is delivered in cycle 24.
- R9: Reset invalidates every line and holds `instr_valid` low. After reset, a previously cached address misses again.
- R10: While `fetch_ready` is low, no response is produced for the waiting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Request accepted this cycle |
| instr_valid | output | 1 | Instruction word returned this cycle |
| instr_data | output | 32 | Returned instruction word |

## Verification
The bench builds the block with its default parameters: 8-word lines, 128 lines, 32-bit addresses and a first-word latency of 7. With these values, each of the eight starting offsets can be missed in turn, and a second word can be probed at every load position from 1 through 7. This covers the wrap-around order and each beat of the pair-and-gap cadence. The 7-bit line field makes it possible to build two tags on one line, and a queued miss that lands exactly at cycle 24.

// File: rtl/icf_pkg.sv
package icf_pkg;

  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] FILL_SALT = 32'hC3A5_5A3C;

  typedef enum logic [1:0] {
    FILL_IDLE,
    FILL_WAIT,
    FILL_STREAM
  } fill_state_e;

  // Backing store model: contents are a fixed function of the word address.
  function automatic logic [DATA_W-1:0] backing_word(input logic [DATA_W-1:0] waddr);
    return waddr ^ FILL_SALT;
  endfunction

endpackage

// File: rtl/icf_tag_store.sv
module icf_tag_store #(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned TAG_W     = 20,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             val_en,
  input  logic [IDX_W-1:0] val_idx
);

  logic [TAG_W-1:0] tag_q [NUM_LINES];
  logic [NUM_LINES-1:0] vld_q;

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (inv_en) vld_q[inv_idx] <= 1'b0;
      if (val_en) vld_q[val_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (inv_en) tag_q[inv_idx] <= inv_tag;
  end

  // R5
  line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_q[$past(inv_idx)]);

  // R5
  line_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_en |=> vld_q[$past(val_idx)]);

endmodule

// File: rtl/icf_data_store.sv
module icf_data_store
  import icf_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 128,
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned DEPTH     = NUM_LINES * LINE_WORDS
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [OFF_W-1:0]  woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic [OFF_W-1:0]  roff,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rdata = mem_q[{ridx, roff}];

  always_ff @(posedge clk) begin
    if (we) mem_q[{widx, woff}] <= wdata;
  end

endmodule

// File: rtl/icf_fill_ctrl.sv
module icf_fill_ctrl
  import icf_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned FIRST_LAT  = 7,
  parameter int unsigned LINE_W     = 27,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned CNT_W     = $clog2(FIRST_LAT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LINE_W-1:0]     start_line,
  input  logic [OFF_W-1:0]      start_off,
  output logic                  busy,
  output logic                  beat,
  output logic [OFF_W-1:0]      beat_off,
  output logic [LINE_W-1:0]     fill_line,
  output logic                  done,
  output logic [LINE_WORDS-1:0] word_have
);

  fill_state_e         state_q;
  logic [CNT_W-1:0]    wait_q;
  logic [1:0]          phase_q;
  logic [OFF_W-1:0]    slot_q;
  logic [OFF_W-1:0]    crit_q;
  logic [LINE_W-1:0]   line_q;
  logic [LINE_WORDS-1:0] have_q;

  assign busy      = (state_q != FILL_IDLE);
  assign beat      = (state_q == FILL_STREAM) && (phase_q != 2'd2);
  assign beat_off  = crit_q + slot_q;
  assign done      = beat && (slot_q == OFF_W'(LINE_WORDS - 1));
  assign fill_line = line_q;
  assign word_have = have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      wait_q  <= '0;
      phase_q <= '0;
      slot_q  <= '0;
      crit_q  <= '0;
      line_q  <= '0;
      have_q  <= '0;
    end else begin
      unique case (state_q)
        FILL_IDLE: begin
          if (start) begin
            state_q <= FILL_WAIT;
            wait_q  <= CNT_W'(1);
            line_q  <= start_line;
            crit_q  <= start_off;
            have_q  <= '0;
          end
        end
        FILL_WAIT: begin
          if (wait_q == CNT_W'(FIRST_LAT - 2)) begin
            state_q <= FILL_STREAM;
            phase_q <= 2'd0;
            slot_q  <= '0;
          end else begin
            wait_q <= wait_q + CNT_W'(1);
          end
        end
        FILL_STREAM: begin
          phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
          if (beat) begin
            have_q[beat_off] <= 1'b1;
            slot_q <= slot_q + OFF_W'(1);
            if (done) state_q <= FILL_IDLE;
          end
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  // R4
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && $past(beat)) |-> !$past(beat, 2));

  // R4
  one_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FILL_STREAM && !beat) |=> beat);

  // R4
  full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(have_q) == LINE_WORDS - 1));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import icf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned NUM_LINES  = 128,
  parameter int unsigned FIRST_LAT  = 7,
  localparam int unsigned BYTE_W    = 2,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned TAG_W     = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int unsigned LINE_W    = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              instr_valid,
  output logic [DATA_W-1:0] instr_data
);

  logic [OFF_W-1:0]  req_off;
  logic [LINE_W-1:0] req_line;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;

  assign req_off  = fetch_addr[BYTE_W +: OFF_W];
  assign req_line = fetch_addr[ADDR_W-1 : BYTE_W + OFF_W];
  assign req_idx  = req_line[IDX_W-1:0];
  assign req_tag  = req_line[LINE_W-1:IDX_W];

  logic                  lk_hit;
  logic                  busy, beat, done;
  logic [OFF_W-1:0]      beat_off;
  logic [LINE_W-1:0]     fill_line;
  logic [LINE_WORDS-1:0] word_have;
  logic                  start;
  logic [DATA_W-1:0]     beat_word, rd_word;

  logic same_line, early_hit, beat_match, cache_hit;

  assign same_line  = busy && (fill_line == req_line);
  assign early_hit  = same_line && word_have[req_off];
  assign beat_match = same_line && beat && (beat_off == req_off);
  assign cache_hit  = lk_hit || early_hit;
  assign fetch_ready = cache_hit || beat_match;
  assign start      = fetch_valid && !cache_hit && !busy;
  assign beat_word  = backing_word(DATA_W'({fill_line, beat_off}));

  icf_tag_store #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_idx  (req_idx),
    .lk_tag  (req_tag),
    .lk_hit  (lk_hit),
    .inv_en  (start),
    .inv_idx (req_idx),
    .inv_tag (req_tag),
    .val_en  (done),
    .val_idx (fill_line[IDX_W-1:0])
  );

  icf_data_store #(
    .NUM_LINES  (NUM_LINES),
    .LINE_WORDS (LINE_WORDS)
  ) u_data (
    .clk   (clk),
    .we    (beat),
    .widx  (fill_line[IDX_W-1:0]),
    .woff  (beat_off),
    .wdata (beat_word),
    .ridx  (req_idx),
    .roff  (req_off),
    .rdata (rd_word)
  );

  icf_fill_ctrl #(
    .LINE_WORDS (LINE_WORDS),
    .FIRST_LAT  (FIRST_LAT),
    .LINE_W     (LINE_W)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_line (req_line),
    .start_off  (req_off),
    .busy       (busy),
    .beat       (beat),
    .beat_off   (beat_off),
    .fill_line  (fill_line),
    .done       (done),
    .word_have  (word_have)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) instr_valid <= 1'b0;
    else        instr_valid <= fetch_valid && fetch_ready;
  end

  always_ff @(posedge clk) begin
    if (fetch_valid && fetch_ready)
      instr_data <= beat_match ? beat_word : rd_word;
  end

  // R8
  queued_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fetch_valid && !lk_hit && !same_line) |-> !fetch_ready);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  // R2
  resp_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> !$isunknown(instr_data));

endmodule

// File: tb/tb_ifetch_cache.sv
module tb_ifetch_cache;

  localparam int CLK_PERIOD = 10;
  localparam int MISS_LAT   = 7;
  localparam int NVEC       = 8;
  // Vector table: critical offset, probe position in load order, expected probe cycle.
  localparam int V_OFF [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int V_PRB [NVEC] = '{1, 2, 3, 4, 5, 6, 7, 1};
  localparam int V_EXP [NVEC] = '{8, 10, 11, 13, 14, 16, 17, 8};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready;
  logic        instr_valid;
  logic [31:0] instr_data;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  ifetch_cache dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .instr_valid (instr_valid),
    .instr_data  (instr_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return {20'(tag), 7'(idx), 3'(off), 2'b00};
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {2'b00, a[31:2]} ^ 32'hC3A5_5A3C;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Presents a request at a falling edge and returns the cycle of its response.
  task automatic do_fetch(input logic [31:0] a, output int at, output logic [31:0] got);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    at  = -1;
    got = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (instr_valid) begin
        at  = cyc;
        got = instr_data;
        break;
      end
    end
  endtask

  task automatic settle(input int c0);
    fetch_valid = 1'b0;
    while (cyc < c0 + 18) @(negedge clk);
  endtask

  initial begin
    int c0, c1, at;
    logic [31:0] got, a;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 instr_valid after reset", 32'(instr_valid), 0);
    chk("R9 ready for uncached line", 32'(fetch_ready), 0);

    for (int i = 0; i < NVEC; i++) begin
      c0 = cyc;
      a = mk(5, 8 + i, V_OFF[i]);
      do_fetch(a, at, got);
      chk("R3 critical word cycle", at - c0, MISS_LAT);
      chk("R2 critical word data", got, exp_word(a));
      a = mk(5, 8 + i, (V_OFF[i] + V_PRB[i]) % 8);
      do_fetch(a, at, got);
      chk("R4 wrap-order probe cycle", at - c0, V_EXP[i]);
      chk("R4 probe data", got, exp_word(a));
      settle(c0);
      for (int w = 0; w < 8; w++) begin
        c1 = cyc;
        a = mk(5, 8 + i, w);
        do_fetch(a, at, got);
        chk("R5 filled word hit latency", at - c1, 1);
        chk("R5 filled word data", got, exp_word(a));
      end
      c1 = cyc;
      a = mk(5, 8 + i, 2) | 32'h3;
      do_fetch(a, at, got);
      chk("R1 byte bits ignored latency", at - c1, 1);
      chk("R1 byte bits ignored data", got, exp_word(a));
      fetch_valid = 1'b0;
      @(negedge clk);
    end

    // Hits during a load, early hit and held word of the loading line
    c0 = cyc;
    do_fetch(mk(5, 40, 4), at, got);
    chk("R3 critical word cycle", at - c0, MISS_LAT);
    a = mk(5, 8, 3);
    do_fetch(a, at, got);
    chk("R6 hit during load cycle", at - c0, 8);
    chk("R6 hit during load data", got, exp_word(a));
    do_fetch(mk(5, 40, 4), at, got);
    chk("R7 arrived word hit cycle", at - c0, 9);
    a = mk(5, 40, 3);
    do_fetch(a, at, got);
    chk("R7 held word cycle", at - c0, 17);
    chk("R7 held word data", got, exp_word(a));
    settle(c0);
    c1 = cyc;
    a = mk(5, 40, 0);
    do_fetch(a, at, got);
    chk("R5 line complete after leaving", at - c1, 1);
    fetch_valid = 1'b0;
    @(negedge clk);

    // Second miss queued behind a running load
    c0 = cyc;
    do_fetch(mk(5, 50, 6), at, got);
    chk("R3 critical word cycle", at - c0, MISS_LAT);
    fetch_addr = mk(5, 51, 1);
    repeat (3) @(negedge clk);
    chk("R10 stalled request not ready", 32'(fetch_ready), 0);
    chk("R10 no response while stalled", 32'(instr_valid), 0);
    a = mk(5, 51, 1);
    do_fetch(a, at, got);
    chk("R8 queued miss word cycle", at - c0, 24);
    chk("R8 queued miss data", got, exp_word(a));
    settle(c0 + 17);

    // Same line number, different tag
    c0 = cyc;
    a = mk(6, 8, 2);
    do_fetch(a, at, got);
    chk("R1 conflicting tag misses", at - c0, MISS_LAT);
    chk("R1 conflicting tag data", got, exp_word(a));
    settle(c0);
    c0 = cyc;
    do_fetch(mk(5, 8, 2), at, got);
    chk("R1 evicted line misses", at - c0, MISS_LAT);
    settle(c0);

    // Reset invalidates cached lines
    fetch_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 instr_valid after second reset", 32'(instr_valid), 0);
    c0 = cyc;
    do_fetch(mk(5, 9, 0), at, got);
    chk("R9 cached line misses after reset", at - c0, MISS_LAT);
    settle(c0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1-to-R10 run actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule